// File: doc/BRIEF.md
# Phase-Offset Toggle Compare Generator

The block drives eight square-wave outputs from one 16-bit up-counting base timer. Each channel holds a compare value. When the base timer equals that value, the channel inverts its output and raises a sticky request flag. All channels share one timer, so they share one period. Each channel's own compare value sets its phase within that period, and every output has a 50% duty cycle.

The timer has three period modes. It can run freely over the full 16-bit range. It can restart after it matches channel 0's compare value. It can restart after it matches a dedicated restart register. A restart takes effect one cycle after the match, so a restart value of n gives a timer period of n+2 cycles and an output period of 2×(n+2). Each channel also has:
- an enable bit,
- a starting-level bit,
- an invert bit.

Software clears the request flags by writing a mask.

The base timer is a three-state machine:
- **IDLE**: `run` is low. The timer is held at 0 and every channel's toggle state is cleared.
- **COUNT**: the timer increments once per clock and compares are live.
- **RELOAD**: the single cycle after a restart match. The timer shows n+1, compares are masked, and the next value is 0.

The transitions are:
- IDLE→COUNT when `run` rises.
- COUNT→RELOAD on a restart match while a restart source is selected.
- RELOAD→COUNT unconditionally.
- Any state→IDLE when `run` falls.

Top module: `phase_toggle_oc`

## Requirements
- R1: After reset, `timer_val` is 0, `irq_flag` is all zero, and each `oc_out[i]` equals `init_lvl[i] ^ inv[i]`.
- R2: With `rst_sel`=2'b00 (free running) and `run` high, `timer_val` rises by one per clock and wraps from 0xFFFF to 0x0000.
- R3: In free-running mode, an enabled channel inverts its output once every 65536 clocks.
- R4: With `rst_sel`=2'b10, the timer period is `rst_val`+2 clocks, and an enabled channel inverts its output every `rst_val`+2 clocks.
- R5: With `rst_sel`=2'b01, channel 0's compare value m0 acts as the restart value, and the period is m0+2 clocks.
- R6: `rst_sel`=2'b11 behaves as free running: the timer passes beyond both restart values.
- R7: Two enabled channels with compare values ma < mb in one period invert their outputs mb−ma clocks apart.
- R8: A channel's `irq_flag` bit sets on its compare match and stays set until a write to `flag_clr` with that bit at 1.
- R9: `oc_out[i]` = `init_lvl[i] ^ inv[i] ^ t[i]`, where t[i] is the toggle state. t[i] is cleared while `run` is low.
- R10: While `ch_en[i]` is 0, `oc_out[i]` holds `init_lvl[i] ^ inv[i]` and `irq_flag[i]` does not set.
- R11: With a restart source selected, a compare value greater than the restart value n never matches. The output stays constant and the flag stays clear.
- R12: While `run` is low, `timer_val` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base-timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timer run control; low stops the timer and clears it |
| rst_sel | input | 2 | Period source: 00 free, 01 channel 0 compare, 10 restart register, 11 free |
| rst_val | input | 16 | Restart register value n |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_idx | input | 3 | Channel index for a compare write |
| cmp_wdata | input | 16 | Compare value to write; used from the next clock edge |
| ch_en | input | 8 | Per-channel enable |
| init_lvl | input | 8 | Per-channel starting level (0 = low) |
| inv | input | 8 | Per-channel output inversion |
| flag_clr | input | 8 | Per-channel flag clear mask, 1 clears |
| oc_out | output | 8 | Channel outputs |
| irq_flag | output | 8 | Sticky per-channel match flags |
| timer_val | output | 16 | Current base timer value |

## Verification
The bench measures the period exactly at the n+2 boundary. A design that restarts directly on the match cycle would show n+1. A design that lets compares fire in the RELOAD cycle would make a channel with compare value n+1 toggle, and the R11 case catches that. The bench drives the forbidden 11 selection and checks that the timer runs past the restart value, so a design that decodes either source bit alone is caught. It also checks that a flag survives cycles with no clear, that a disabled channel stays at its starting level under both invert settings, and that the free-running half period is exactly 65536 with a clean wrap.

// File: rtl/poc_pkg.sv
package poc_pkg;

    typedef enum logic [1:0] {
        BT_IDLE   = 2'd0,
        BT_COUNT  = 2'd1,
        BT_RELOAD = 2'd2
    } bt_state_e;

    typedef enum logic [1:0] {
        RS_FREE = 2'd0,
        RS_CH0  = 2'd1,
        RS_REG  = 2'd2,
        RS_BOTH = 2'd3
    } rsel_e;

endpackage

// File: rtl/poc_base_timer.sv
module poc_base_timer
    import poc_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [1:0]    rsel,
    input  logic [TW-1:0] ch0_cmp,
    input  logic [TW-1:0] rst_val,
    output logic [TW-1:0] tmr,
    output logic          cmp_ok
);

    bt_state_e     state_q, state_d;
    logic [TW-1:0] tmr_q;
    logic [TW-1:0] src_val;
    logic          src_on;
    logic          hit;

    // Restart source decode; both bits set falls back to free running
    always_comb begin
        unique case (rsel_e'(rsel))
            RS_CH0: begin
                src_on  = 1'b1;
                src_val = ch0_cmp;
            end
            RS_REG: begin
                src_on  = 1'b1;
                src_val = rst_val;
            end
            default: begin
                src_on  = 1'b0;
                src_val = rst_val;
            end
        endcase
    end

    assign hit = src_on && (tmr_q == src_val);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BT_IDLE:   state_d = run ? BT_COUNT : BT_IDLE;
            BT_COUNT:  state_d = !run ? BT_IDLE : (hit ? BT_RELOAD : BT_COUNT);
            BT_RELOAD: state_d = !run ? BT_IDLE : BT_COUNT;
            default:   state_d = BT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BT_IDLE;
        else        state_q <= state_d;
    end

    // Timer value per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (!run) begin
            tmr_q <= '0;
        end else begin
            unique case (state_q)
                BT_IDLE:   tmr_q <= '0;
                BT_COUNT:  tmr_q <= tmr_q + TW'(1);
                BT_RELOAD: tmr_q <= '0;
                default:   tmr_q <= '0;
            endcase
        end
    end

    assign tmr    = tmr_q;
    assign cmp_ok = (state_q == BT_COUNT);

endmodule

// File: rtl/poc_channel.sv
module poc_channel #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tmr,
    input  logic          cmp_ok,
    input  logic          stopped,
    input  logic          en,
    input  logic          we,
    input  logic [TW-1:0] wdata,
    input  logic          clr,
    output logic          tg,
    output logic          flag,
    output logic [TW-1:0] cmp_q
);

    logic match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cmp_q <= '0;
        else if (we) cmp_q <= wdata;
    end

    assign match = cmp_ok && en && (tmr == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              tg <= 1'b0;
        else if (stopped || !en) tg <= 1'b0;
        else if (match)          tg <= ~tg;
    end

    // A match in the same cycle as a clear keeps the flag set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag <= 1'b0;
        else if (match) flag <= 1'b1;
        else if (clr)   flag <= 1'b0;
    end

endmodule

// File: rtl/phase_toggle_oc.sv
module phase_toggle_oc #(
    parameter  int NCH = 8,
    parameter  int TW  = 16,
    localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [1:0]     rst_sel,
    input  logic [TW-1:0]  rst_val,
    input  logic           cmp_we,
    input  logic [IW-1:0]  cmp_idx,
    input  logic [TW-1:0]  cmp_wdata,
    input  logic [NCH-1:0] ch_en,
    input  logic [NCH-1:0] init_lvl,
    input  logic [NCH-1:0] inv,
    input  logic [NCH-1:0] flag_clr,
    output logic [NCH-1:0] oc_out,
    output logic [NCH-1:0] irq_flag,
    output logic [TW-1:0]  timer_val
);

    logic [TW-1:0]  tmr;
    logic           cmp_ok;
    logic [NCH-1:0] tg;
    logic [TW-1:0]  cmp_arr [NCH];

    poc_base_timer #(.TW(TW)) u_bt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .rsel    (rst_sel),
        .ch0_cmp (cmp_arr[0]),
        .rst_val (rst_val),
        .tmr     (tmr),
        .cmp_ok  (cmp_ok)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        poc_channel #(.TW(TW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tmr     (tmr),
            .cmp_ok  (cmp_ok),
            .stopped (!run),
            .en      (ch_en[i]),
            .we      (cmp_we && (cmp_idx == IW'(i))),
            .wdata   (cmp_wdata),
            .clr     (flag_clr[i]),
            .tg      (tg[i]),
            .flag    (irq_flag[i]),
            .cmp_q   (cmp_arr[i])
        );
        assign oc_out[i] = init_lvl[i] ^ inv[i] ^ tg[i];
    end

    assign timer_val = tmr;

endmodule

// File: rtl/poc_checker.sv
module poc_checker #(
    parameter  int NCH = 8,
    parameter  int TW  = 16,
    localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run,
    input logic [1:0]     rst_sel,
    input logic [TW-1:0]  rst_val,
    input logic           cmp_we,
    input logic [IW-1:0]  cmp_idx,
    input logic [TW-1:0]  cmp_wdata,
    input logic [NCH-1:0] ch_en,
    input logic [NCH-1:0] init_lvl,
    input logic [NCH-1:0] inv,
    input logic [NCH-1:0] flag_clr,
    input logic [NCH-1:0] oc_out,
    input logic [NCH-1:0] irq_flag,
    input logic [TW-1:0]  timer_val
);

    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (timer_val == '0)); // R12

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> ((timer_val == $past(timer_val) + TW'(1)) || (timer_val == '0))); // R2

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(irq_flag) & ~$past(flag_clr) & ~irq_flag) == '0)); // R8

    AST_DIS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (((oc_out ^ init_lvl ^ inv) & ~ch_en & ~$past(ch_en)) == '0)); // R10

    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_flag & ~$past(irq_flag) & ~$past(ch_en)) == '0)); // R10

endmodule

bind phase_toggle_oc poc_checker #(.NCH(NCH), .TW(TW)) u_chk (.*);

// File: tb/tb_phase_toggle_oc.sv
`timescale 1ns/1ps
module tb_phase_toggle_oc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  rst_sel = 2'b00;
    logic [15:0] rst_val = '0;
    logic        cmp_we = 1'b0;
    logic [2:0]  cmp_idx = '0;
    logic [15:0] cmp_wdata = '0;
    logic [7:0]  ch_en = '0;
    logic [7:0]  init_lvl = '0;
    logic [7:0]  inv = '0;
    logic [7:0]  flag_clr = '0;
    logic [7:0]  oc_out;
    logic [7:0]  irq_flag;
    logic [15:0] timer_val;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    phase_toggle_oc dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_cmp(input int ch, input int val);
        @(negedge clk);
        cmp_we = 1'b1; cmp_idx = 3'(ch); cmp_wdata = 16'(val);
        @(negedge clk);
        cmp_we = 1'b0;
    endtask

    task automatic start(input logic [1:0] sel, input int n);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        rst_sel = sel; rst_val = 16'(n); run = 1'b1;
    endtask

    task automatic wait_change(input int ch, input int maxc, output int cnt);
        logic v;
        v = oc_out[ch];
        cnt = 0;
        while (cnt <= maxc) begin
            @(negedge clk);
            cnt++;
            if (oc_out[ch] != v) break;
        end
    endtask

    task automatic t_reset();
        check(timer_val == 0, "R1 timer", int'(timer_val), 0);
        check(irq_flag == 0, "R1 flags", int'(irq_flag), 0);
        check(oc_out == 0, "R1 outputs", int'(oc_out), 0);
    endtask

    task automatic t_levels();
        init_lvl[6] = 1'b1; inv[6] = 1'b1;
        @(negedge clk);
        check(oc_out[6] == 1'b0, "R9 init1 inv1", int'(oc_out[6]), 0);
        inv[6] = 1'b0;
        @(negedge clk);
        check(oc_out[6] == 1'b1, "R9 init1 inv0", int'(oc_out[6]), 1);
        wr_cmp(6, 4);
        ch_en[6] = 1'b1;
        start(2'b10, 10);
        wait_change(6, 40, c6);
        check(oc_out[6] == 1'b0, "R9 toggled", int'(oc_out[6]), 0);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check(oc_out[6] == 1'b1, "R9 stop restores", int'(oc_out[6]), 1);
        check(timer_val == 0, "R12 stop holds zero", int'(timer_val), 0);
        repeat (5) @(negedge clk);
        check(timer_val == 0, "R12 still zero", int'(timer_val), 0);
        ch_en[6] = 1'b0; init_lvl[6] = 1'b0;
    endtask
    int c6;

    task automatic t_free();
        int c;
        int prev;
        bit wrapped;
        wr_cmp(1, 100);
        ch_en = 8'h02;
        start(2'b00, 0);
        wait_change(1, 200, c);
        check(c == 102, "R3 first toggle", c, 102);
        c = 0; wrapped = 0; prev = int'(timer_val);
        while (c < 70000) begin
            @(negedge clk);
            c++;
            if (prev == 16'hFFFF) wrapped = (timer_val == 0);
            prev = int'(timer_val);
            if (oc_out[1] == 1'b0) break;
        end
        check(c == 65536, "R3 half period", c, 65536);
        check(wrapped, "R2 wrap to zero", int'(wrapped), 1);
        ch_en = 8'h00;
    endtask

    task automatic t_reg_period();
        int c;
        wr_cmp(3, 2);
        wr_cmp(4, 7);
        ch_en = 8'h18;
        start(2'b10, 10);
        while (timer_val != 5) @(negedge clk);
        c = 0;
        do begin @(negedge clk); c++; end while (timer_val != 5 && c < 100);
        check(c == 12, "R4 timer period", c, 12);
        wait_change(3, 40, c);
        wait_change(3, 40, c);
        check(c == 12, "R4 output half period", c, 12);
        wait_change(4, 40, c);
        check(c == 5, "R7 phase offset", c, 5);
        ch_en = 8'h00;
    endtask

    task automatic t_ch0_period();
        int c;
        wr_cmp(0, 6);
        wr_cmp(3, 2);
        ch_en = 8'h09;
        start(2'b01, 1000);
        wait_change(3, 40, c);
        wait_change(3, 40, c);
        check(c == 8, "R5 ch0 restart period", c, 8);
        ch_en = 8'h00;
    endtask

    task automatic t_both();
        int c;
        wr_cmp(0, 5);
        wr_cmp(2, 12);
        ch_en = 8'h04;
        start(2'b11, 5);
        wait_change(2, 40, c);
        check(c == 14, "R6 both selected free running", c, 14);
        check(timer_val > 7, "R6 timer passes restart", int'(timer_val), 13);
        ch_en = 8'h00;
    endtask

    task automatic t_flag();
        int c;
        @(negedge clk);
        run = 1'b0; flag_clr = 8'hFF;
        @(negedge clk);
        flag_clr = 8'h00;
        check(irq_flag == 0, "R8 flags cleared", int'(irq_flag), 0);
        wr_cmp(2, 3);
        ch_en = 8'h04;
        start(2'b10, 10);
        wait_change(2, 40, c);
        check(irq_flag[2] == 1'b1, "R8 set on match", int'(irq_flag[2]), 1);
        repeat (5) @(negedge clk);
        check(irq_flag[2] == 1'b1, "R8 sticky", int'(irq_flag[2]), 1);
        flag_clr = 8'h04;
        @(negedge clk);
        flag_clr = 8'h00;
        check(irq_flag[2] == 1'b0, "R8 cleared by write", int'(irq_flag[2]), 0);
        wait_change(2, 40, c);
        check(irq_flag[2] == 1'b1, "R8 set again", int'(irq_flag[2]), 1);
        ch_en = 8'h00;
    endtask

    task automatic t_disabled();
        logic bad;
        @(negedge clk);
        run = 1'b0; flag_clr = 8'hFF;
        @(negedge clk);
        flag_clr = 8'h00;
        wr_cmp(5, 2);
        init_lvl[5] = 1'b1;
        start(2'b10, 10);
        bad = 1'b0;
        repeat (30) begin @(negedge clk); if (oc_out[5] != 1'b1) bad = 1'b1; end
        check(!bad, "R10 disabled holds level", int'(bad), 0);
        check(irq_flag[5] == 1'b0, "R10 disabled no flag", int'(irq_flag[5]), 0);
        inv[5] = 1'b1;
        @(negedge clk);
        check(oc_out[5] == 1'b0, "R10 disabled inverted", int'(oc_out[5]), 0);
        inv[5] = 1'b0; init_lvl[5] = 1'b0;
    endtask

    task automatic t_beyond();
        logic bad;
        logic v;
        wr_cmp(7, 11);
        ch_en = 8'h80;
        start(2'b10, 10);
        v = oc_out[7];
        bad = 1'b0;
        repeat (60) begin @(negedge clk); if (oc_out[7] != v) bad = 1'b1; end
        check(!bad, "R11 out constant", int'(bad), 0);
        check(irq_flag[7] == 1'b0, "R11 no flag", int'(irq_flag[7]), 0);
        ch_en = 8'h00;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_levels();
        t_reg_period();
        t_ch0_period();
        t_both();
        t_flag();
        t_disabled();
        t_beyond();
        t_free();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule